// File: doc/BRIEF.md
# Bidirectional Gate-Line Scan Shift Register

This block is the digital core of a panel row-scan driver. A start pulse is shifted through a chain of stages, one stage on each rising clock edge, so that a single gate-line output is active per clock during a frame scan. The chain runs in either direction. A direction input decides which end pin takes the start pulse in and which end pin passes the pulse on to the next driver in a cascade.

Two active-low overrides act on the gate-line outputs only. One forces all lines inactive. The other forces all lines active and wins when both are asserted. Neither override touches the stored shift pattern. Two edge lines next to the ends of the chain are always held inactive.

Output levels are logic 1 for the positive drive rail and logic 0 for the negative rail.

Top module: `gate_scan_chain`

## Requirements
- R1: The chain holds `N` stages (parameter, default 300). `scan_out[i]` drives gate line i+1. All stages update together on each rising edge of `clk`.
- R2: With `fwd`=1, the value on `head_in` at a rising edge enters stage 0. On the same edge each stage i passes its value to stage i+1.
- R3: With `fwd`=0, the value on `tail_in` at a rising edge enters stage N-1. On the same edge each stage i passes its value to stage i-1.
- R4: `tail_out` always carries stage N-1 and `head_out` always carries stage 0. The cascade drive enable is `tail_drv`=`fwd` and `head_drv`=!`fwd`. The overrides do not affect these outputs.
- R5: While `oe_n`=0 and `all_on_n`=1, every `scan_out` bit is 0. The stored pattern keeps shifting and reappears when `oe_n` returns to 1.
- R6: While `all_on_n`=0, every `scan_out` bit is 1, whatever the value of `oe_n`. The stored pattern is kept.
- R7: `edge_first` and `edge_last` are 0 at all times, whatever the shift data.
- R8: A synchronous active-high `rst` clears every stage to 0 at the next rising edge.
- R9: A change of `fwd` applies from the next rising edge onward. It neither clears nor reorders the stored stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| fwd | input | 1 | Scan direction: 1 = stage 0 toward N-1, 0 = reverse |
| head_in | input | 1 | Start pulse input at the stage-0 end (used when fwd=1) |
| tail_in | input | 1 | Start pulse input at the stage-(N-1) end (used when fwd=0) |
| oe_n | input | 1 | Active-low output enable; 0 forces all lines low |
| all_on_n | input | 1 | Active-low all-on; 0 forces all lines high (tie high when unused) |
| head_out | output | 1 | Cascade value at the stage-0 end |
| head_drv | output | 1 | Drive enable for the stage-0 end pin |
| tail_out | output | 1 | Cascade value at the stage-(N-1) end |
| tail_drv | output | 1 | Drive enable for the stage-(N-1) end pin |
| scan_out | output | N | Gate-line outputs |
| edge_first | output | 1 | Auxiliary edge line beside stage 0, held low |
| edge_last | output | 1 | Auxiliary edge line beside stage N-1, held low |

## Verification
The bench builds the chain with `N`=16 instead of 300. At that length a start pulse can be followed through the whole chain and out of the cascade pin in each direction within a few dozen cycles. The short chain also lets random direction flips, overrides and pulse trains produce patterns that wrap through both ends many times in one run. The logic is the same at every length, so the default build differs only in how long a pulse takes to cross.

// File: rtl/gate_scan_chain.sv
module gate_scan_chain #(
  parameter int N = 300
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fwd,
  input  logic         head_in,
  input  logic         tail_in,
  input  logic         oe_n,
  input  logic         all_on_n,
  output logic         head_out,
  output logic         head_drv,
  output logic         tail_out,
  output logic         tail_drv,
  output logic [N-1:0] scan_out,
  output logic         edge_first,
  output logic         edge_last
);
  localparam int LAST = N - 1;

  logic [N-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst)      stg <= '0;
    else if (fwd) stg <= {stg[LAST-1:0], head_in};
    else          stg <= {tail_in, stg[LAST:1]};
  end

  assign scan_out   = !all_on_n ? {N{1'b1}} : (!oe_n ? '0 : stg);
  assign head_out   = stg[0];
  assign tail_out   = stg[LAST];
  assign head_drv   = !fwd;
  assign tail_drv   = fwd;
  assign edge_first = 1'b0;
  assign edge_last  = 1'b0;

  p_fwd_entry_r2: assert property (@(posedge clk) disable iff (rst)
    fwd |=> stg[0] == $past(head_in));
  p_fwd_move_r2: assert property (@(posedge clk) disable iff (rst)
    fwd |=> stg[LAST:1] == $past(stg[LAST-1:0]));
  p_rev_entry_r3: assert property (@(posedge clk) disable iff (rst)
    !fwd |=> stg[LAST] == $past(tail_in));
  p_rev_move_r3: assert property (@(posedge clk) disable iff (rst)
    !fwd |=> stg[LAST-1:0] == $past(stg[LAST:1]));
  p_clear_r8: assert property (@(posedge clk)
    rst |=> stg == '0);
  p_all_on_r6: assert property (@(posedge clk) disable iff (rst)
    !all_on_n |-> &scan_out);
  p_blank_r5: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && all_on_n) |-> scan_out == '0);
  p_one_driver_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot({head_drv, tail_drv}) && tail_drv == fwd);
endmodule

// File: tb/gate_scan_chain_tb.sv
module gate_scan_chain_tb;
  localparam int N = 16;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, fwd = 1, head_in = 0, tail_in = 0, oe_n = 1, all_on_n = 1;
  logic head_out, head_drv, tail_out, tail_drv, edge_first, edge_last;
  logic [N-1:0] scan_out;
  logic [N-1:0] model = '0;
  int runs = 0, fails = 0;
  bit chk_en = 0;

  gate_scan_chain #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .fwd(fwd), .head_in(head_in), .tail_in(tail_in),
    .oe_n(oe_n), .all_on_n(all_on_n), .head_out(head_out), .head_drv(head_drv),
    .tail_out(tail_out), .tail_drv(tail_drv), .scan_out(scan_out),
    .edge_first(edge_first), .edge_last(edge_last));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [N-1:0] exp_scan(logic [N-1:0] m, logic oe, logic ao);
    if (!ao) return {N{1'b1}};
    if (!oe) return '0;
    return m;
  endfunction

  function automatic logic [N-1:0] next_state(logic [N-1:0] m, logic r, logic f,
                                              logic h, logic t);
    if (r) return '0;
    if (f) return {m[N-2:0], h};
    return {t, m[N-1:1]};
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic r, logic f, logic h, logic t, logic oe, logic ao);
    @(negedge clk);
    rst = r; fwd = f; head_in = h; tail_in = t; oe_n = oe; all_on_n = ao;
    #1;
    if (chk_en) begin
      chk(tag, scan_out, exp_scan(model, oe, ao));
      chk("R4 head_out", N'(head_out), N'(model[0]));
      chk("R4 tail_out", N'(tail_out), N'(model[N-1]));
      chk("R4 drv", N'({head_drv, tail_drv}), N'({!f, f}));
      chk("R7 edges", N'({edge_first, edge_last}), '0);
    end
    @(posedge clk);
    model = next_state(model, r, f, h, t);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    step("R8", 1, 1, 0, 0, 1, 1);
    step("R8", 1, 1, 0, 0, 1, 1);
    chk_en = 1;
    step("R8 reset state", 0, 1, 0, 0, 1, 1);
    // R1 R2: single pulse forward across the whole chain and out at tail
    step("R2 load", 0, 1, 1, 0, 1, 1);
    for (int i = 0; i < N + 2; i++) step("R2 travel", 0, 1, 0, 0, 1, 1);
    // R3: single pulse reverse
    step("R3 load", 0, 0, 0, 1, 1, 1);
    for (int i = 0; i < N + 2; i++) step("R3 travel", 0, 0, 0, 0, 1, 1);
    // R5: blank mid-scan, pattern resumes after release
    step("R5 load", 0, 1, 1, 0, 1, 1);
    for (int i = 0; i < 4; i++) step("R5 blank", 0, 1, 0, 0, 0, 1);
    step("R5 release", 0, 1, 0, 0, 1, 1);
    // R6: all-on over blank, pattern kept
    for (int i = 0; i < 3; i++) step("R6 all-on", 0, 1, 0, 0, 0, 0);
    step("R6 release", 0, 1, 0, 0, 1, 1);
    // R9: reverse mid-scan, pulse walks back
    for (int i = 0; i < 4; i++) step("R9 turn", 0, 0, 0, 0, 1, 1);
    step("R9 turn back", 0, 1, 0, 0, 1, 1);
    // R8: reset with a loaded pattern
    step("R8 fill", 0, 1, 1, 0, 1, 1);
    step("R8 fill", 0, 1, 1, 0, 1, 1);
    step("R8 assert", 1, 1, 1, 1, 1, 1);
    step("R8 cleared", 0, 1, 0, 0, 1, 1);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic f, h, t, oe, ao, r;
      f  = ($urandom % 8) != 0 ? fwd : ~fwd;
      h  = ($urandom % 5) == 0;
      t  = ($urandom % 5) == 0;
      oe = ($urandom % 6) != 0;
      ao = ($urandom % 9) != 0;
      r  = ($urandom % 200) == 0;
      step(!ao ? "R6 rnd" : (!oe ? "R5 rnd" : (f ? "R2 rnd" : "R3 rnd")), r, f, h, t, oe, ao);
    end
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule